// File: doc/BRIEF.md
# Bus Cycle Master with Ready-Stretched Memory and I/O Cycles

This block turns a single request from local logic into one bus cycle on a parallel system bus. A cycle reads or writes either memory or an I/O port. It lasts a fixed number of clocks. The addressed target can stretch the cycle by holding a channel-ready input low. The master owns the address lines and four separate active-low strobes, one each for memory read, memory write, I/O read and I/O write. It drives write data for the whole cycle and captures read data on the edge that ends the cycle.

The local side raises `req_i` while `busy_o` is low and presents an address, write data, a write flag and an I/O flag. The master latches these values at the accepting edge. It ignores the request inputs until the cycle has ended. When the cycle is over it raises `done_o` for one clock, and `rdata_o` then holds the value read by the last read cycle. Memory addresses are 20 bits wide. I/O cycles use a 16-bit space, and the upper address lines are driven low for them.

Top module: `isa_cycle_master`

## Requirements
- R1: With `busy_o` low, `req_i` high at a rising edge starts a cycle. `busy_o` is high for 4 + W clocks, where W is the number of wait clocks inserted.
- R2: Throughout a cycle `bus_addr_o` holds the address latched at acceptance. For I/O cycles bits 19:16 are 0. Outside a cycle `bus_addr_o` is 0.
- R3: The strobe index is {io, we}: 0 is `memr_no`, 1 is `memw_no`, 2 is `ior_no` and 3 is `iow_no`. Only the selected strobe goes low. It is low from the second clock of the cycle through its last clock, and all strobes are high otherwise.
- R4: `chan_rdy_i` is sampled at the edge that ends the third clock and at the end of each wait clock. Each low sample adds one wait clock.
- R5: After 6 wait clocks the cycle proceeds to its final clock whatever `chan_rdy_i` is, so a cycle never exceeds 10 clocks.
- R6: `done_o` is high for exactly the one clock after the last clock of a cycle, and `busy_o` is low in that clock.
- R7: For a read, `rdata_o` takes the value of `bus_din_i` at the edge that ends the cycle. A write leaves `rdata_o` unchanged.
- R8: During a write cycle `bus_doe_o` is high and `bus_dout_o` holds the latched write data in every clock. During a read and when idle, `bus_doe_o` is low.
- R9: Changes on `req_i`, `addr_i`, `wdata_i`, `we_i` and `io_i` while `busy_o` is high do not affect the cycle in progress.
- R10: While reset is applied and after it is released, `busy_o` and `done_o` are 0, all strobes are 1, `bus_addr_o` is 0, `bus_doe_o` is 0 and `rdata_o` is 0.
- R11: A request present in the `done_o` clock is accepted at the end of that clock, so a new cycle starts with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request, honoured only while idle |
| addr_i | input | 20 | Request address |
| wdata_i | input | 8 | Request write data |
| we_i | input | 1 | 1 for a write, 0 for a read |
| io_i | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock pulse after a cycle ends |
| rdata_o | output | 8 | Data captured by the last read |
| bus_addr_o | output | 20 | Bus address |
| memr_no | output | 1 | Memory read strobe, active low |
| memw_no | output | 1 | Memory write strobe, active low |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |
| bus_dout_o | output | 8 | Bus write data |
| bus_doe_o | output | 1 | Bus write data enable |
| bus_din_i | input | 8 | Bus read data |
| chan_rdy_i | input | 1 | Channel ready from the target |

## Verification
Two functions can fall in the same clock: the completion pulse of one cycle and the acceptance of the next request. The bench raises the next request in the very clock where `done_o` is high. It then checks that the pulse still lasts one clock and that the new cycle starts its address and strobe timing at once. The bench also holds `req_i` high with changed address and data during a cycle to show that acceptance is blocked while busy. Wait counts of zero, six and more than six cover the ready-sampling boundary.

// File: rtl/isa_cyc_pkg.sv
package isa_cyc_pkg;
  typedef enum logic [1:0] {
    K_MEM_RD = 2'd0,
    K_MEM_WR = 2'd1,
    K_IO_RD  = 2'd2,
    K_IO_WR  = 2'd3
  } cyc_kind_e;
  localparam int unsigned N_KINDS = 4;
endpackage

// File: rtl/isa_cyc_seq.sv
module isa_cyc_seq #(
  parameter int unsigned BASE_CLKS = 4,
  parameter int unsigned READY_CLK = 3,
  parameter int unsigned MAX_WAIT  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rdy_i,
  output logic accept_o,
  output logic active_o,
  output logic strobe_o,
  output logic last_o,
  output logic done_o
);
  localparam int unsigned PW = $clog2(BASE_CLKS + 1);
  localparam int unsigned WW = $clog2(MAX_WAIT + 1);

  logic          active_q, done_q;
  logic [PW-1:0] phase_q;
  logic [WW-1:0] waits_q;
  logic          stall;

  assign accept_o = !active_q && req_i;
  assign last_o   = active_q && (phase_q == PW'(BASE_CLKS));
  assign strobe_o = active_q && (phase_q >= PW'(2));
  // hold the ready phase while the target is not ready and budget remains
  assign stall    = active_q && (phase_q == PW'(READY_CLK)) && !rdy_i
                    && (waits_q != WW'(MAX_WAIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      waits_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        active_q <= 1'b1;
        phase_q  <= PW'(1);
        waits_q  <= '0;
      end else if (active_q) begin
        if (stall) begin
          waits_q <= waits_q + WW'(1);
        end else if (last_o) begin
          active_q <= 1'b0;
          phase_q  <= '0;
        end else begin
          phase_q <= phase_q + PW'(1);
        end
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
endmodule

// File: rtl/isa_cyc_dp.sv
module isa_cyc_dp
  import isa_cyc_pkg::*;
#(
  parameter int unsigned MEM_AW = 20,
  parameter int unsigned IO_AW  = 16,
  parameter int unsigned DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              active_i,
  input  logic              last_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              io_i,
  input  logic [DW-1:0]     din_i,
  output logic [MEM_AW-1:0] addr_o,
  output logic [DW-1:0]     dout_o,
  output logic              doe_o,
  output logic [DW-1:0]     rdata_o,
  output cyc_kind_e         kind_o
);
  localparam logic [MEM_AW-1:0] IO_MASK = {{(MEM_AW-IO_AW){1'b0}}, {IO_AW{1'b1}}};

  logic [MEM_AW-1:0] addr_q;
  logic [DW-1:0]     wdata_q, rdata_q;
  logic              we_q, io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      io_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= io_i ? (addr_i & IO_MASK) : addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
        io_q    <= io_i;
      end
      if (last_i && !we_q) rdata_q <= din_i;
    end
  end

  assign addr_o  = active_i ? addr_q : '0;
  assign dout_o  = wdata_q;
  assign doe_o   = active_i && we_q;
  assign rdata_o = rdata_q;
  assign kind_o  = cyc_kind_e'({io_q, we_q});
endmodule

// File: rtl/isa_cyc_strb.sv
module isa_cyc_strb
  import isa_cyc_pkg::*;
(
  input  logic               on_i,
  input  cyc_kind_e          kind_i,
  output logic [N_KINDS-1:0] strb_no
);
  for (genvar i = 0; i < N_KINDS; i++) begin : g_strb
    assign strb_no[i] = !(on_i && (kind_i == cyc_kind_e'(i)));
  end
endmodule

// File: rtl/isa_cycle_master.sv
module isa_cycle_master
  import isa_cyc_pkg::*;
#(
  parameter int unsigned MEM_AW    = 20,
  parameter int unsigned IO_AW     = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned BASE_CLKS = 4,
  parameter int unsigned READY_CLK = 3,
  parameter int unsigned MAX_WAIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              io_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic [MEM_AW-1:0] bus_addr_o,
  output logic              memr_no,
  output logic              memw_no,
  output logic              ior_no,
  output logic              iow_no,
  output logic [DW-1:0]     bus_dout_o,
  output logic              bus_doe_o,
  input  logic [DW-1:0]     bus_din_i,
  input  logic              chan_rdy_i
);
  logic               accept, active, strobe_on, last;
  cyc_kind_e          kind;
  logic [N_KINDS-1:0] strb_n;

  isa_cyc_seq #(
    .BASE_CLKS(BASE_CLKS), .READY_CLK(READY_CLK), .MAX_WAIT(MAX_WAIT)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rdy_i(chan_rdy_i),
    .accept_o(accept), .active_o(active), .strobe_o(strobe_on),
    .last_o(last), .done_o(done_o)
  );

  isa_cyc_dp #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .DW(DW)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .active_i(active),
    .last_i(last), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .io_i(io_i), .din_i(bus_din_i), .addr_o(bus_addr_o), .dout_o(bus_dout_o),
    .doe_o(bus_doe_o), .rdata_o(rdata_o), .kind_o(kind)
  );

  isa_cyc_strb u_strb (.on_i(strobe_on), .kind_i(kind), .strb_no(strb_n));

  assign busy_o  = active;
  assign memr_no = strb_n[K_MEM_RD];
  assign memw_no = strb_n[K_MEM_WR];
  assign ior_no  = strb_n[K_IO_RD];
  assign iow_no  = strb_n[K_IO_WR];
endmodule

// File: rtl/isa_cyc_chk.sv
module isa_cyc_chk #(
  parameter int unsigned MEM_AW    = 20,
  parameter int unsigned IO_AW     = 16,
  parameter int unsigned BASE_CLKS = 4,
  parameter int unsigned MAX_WAIT  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [MEM_AW-1:0] bus_addr_o,
  input logic              memr_no,
  input logic              memw_no,
  input logic              ior_no,
  input logic              iow_no,
  input logic              bus_doe_o
);
  logic [7:0] len_q;
  logic       strb_any;

  assign strb_any = !(memr_no && memw_no && ior_no && iow_no);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (!busy_o) len_q <= '0;
    else              len_q <= len_q + 8'd1;
  end

  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{memr_no, memw_no, ior_no, iow_no}));
  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !strb_any && !bus_doe_o && bus_addr_o == '0);
  p_addr_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_any |-> $past(busy_o));
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !$past(done_o) |-> $stable(bus_addr_o));
  p_io_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ior_no || !iow_no) |-> bus_addr_o[MEM_AW-1:IO_AW] == '0);
  p_len_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> len_q < 8'(BASE_CLKS + MAX_WAIT));
  p_len_min_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> len_q >= 8'(BASE_CLKS));
  p_done_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind isa_cycle_master isa_cyc_chk #(
  .MEM_AW(MEM_AW), .IO_AW(IO_AW), .BASE_CLKS(BASE_CLKS), .MAX_WAIT(MAX_WAIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .bus_addr_o(bus_addr_o), .memr_no(memr_no), .memw_no(memw_no),
  .ior_no(ior_no), .iow_no(iow_no), .bus_doe_o(bus_doe_o)
);

// File: tb/isa_cycle_master_bench.sv
module isa_cycle_master_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic        io_i = 1'b0;
  logic        busy_o, done_o;
  logic [7:0]  rdata_o;
  logic [19:0] bus_addr_o;
  logic        memr_no, memw_no, ior_no, iow_no;
  logic [7:0]  bus_dout_o;
  logic        bus_doe_o;
  logic [7:0]  bus_din_i = '0;
  logic        chan_rdy_i = 1'b1;

  int   n_chk = 0, n_bad = 0;
  bit   ended = 0;
  logic [7:0] exp_rd = '0;

  always #10 clk_i = ~clk_i;

  isa_cycle_master u_isa_cycle_master (.*);

  function automatic logic [19:0] f_addr(input logic [19:0] a, input logic io);
    return io ? {4'h0, a[15:0]} : a;
  endfunction

  // {iow, ior, memw, memr}, index {io, we}
  function automatic logic [3:0] f_strb(input int n, input logic we, input logic io);
    return (n >= 2) ? ~(4'b0001 << {io, we}) : 4'hF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " R1 busy"}, 32'(busy_o), 0);
    check({tag, " R3 strobes"}, 32'({iow_no, ior_no, memw_no, memr_no}), 32'hF);
    check({tag, " R2 addr"}, 32'(bus_addr_o), 0);
    check({tag, " R8 doe"}, 32'(bus_doe_o), 0);
  endtask

  // called at a negedge; returns at the negedge of the done clock
  task automatic run_cyc(input logic [19:0] a, input logic [7:0] wd, input logic we,
                         input logic io, input int k, input bit hold_req);
    int          w;
    int          len;
    logic [7:0]  rd;
    w   = (k > 6) ? 6 : k;
    len = 4 + w;
    rd  = 8'($urandom);
    req_i = 1'b1; addr_i = a; wdata_i = wd; we_i = we; io_i = io;
    bus_din_i = rd; chan_rdy_i = 1'b1;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk_i);
      check("R1 busy in cycle", 32'(busy_o), 1);
      check("R6 no done in cycle", 32'(done_o), 0);
      check("R2 addr", 32'(bus_addr_o), 32'(f_addr(a, io)));
      check("R3 strobe", 32'({iow_no, ior_no, memw_no, memr_no}), 32'(f_strb(n, we, io)));
      check("R8 doe", 32'(bus_doe_o), 32'(we));
      if (we) check("R8 dout", 32'(bus_dout_o), 32'(wd));
      if (n == 1) begin
        if (hold_req) begin  // R9: keep requesting with other values
          addr_i = ~a; wdata_i = ~wd; we_i = ~we; io_i = ~io;
        end else req_i = 1'b0;
      end
      if (n == len) req_i = 1'b0;
      chan_rdy_i = (n >= 3 && n < 3 + k) ? 1'b0 : 1'b1;  // R4 R5
    end
    @(negedge clk_i);
    chan_rdy_i = 1'b1;
    if (!we) exp_rd = rd;
    check("R6 done pulse", 32'(done_o), 1);
    check("R1 R5 busy ends", 32'(busy_o), 0);
    check("R7 rdata", 32'(rdata_o), 32'(exp_rd));
  endtask

  task automatic gap();
    @(negedge clk_i);
    check("R6 done one clock", 32'(done_o), 0);
    check_idle("gap");
  endtask

  initial begin
    void'($urandom(32'd1234));
    #5;
    check_idle("R10 in reset");
    check("R10 done", 32'(done_o), 0);
    check("R10 rdata", 32'(rdata_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R10 after reset");
    // directed corners
    run_cyc(20'hABCDE, 8'h00, 1'b0, 1'b0, 0, 0); gap();     // mem read, no wait
    run_cyc(20'hFEDCB, 8'h5A, 1'b1, 1'b1, 0, 0); gap();     // io write, upper zero
    check("R7 rdata held after write", 32'(rdata_o), 32'(exp_rd));
    run_cyc(20'h12345, 8'h00, 1'b0, 1'b1, 1, 0); gap();     // R4 one wait
    run_cyc(20'h54321, 8'hC3, 1'b1, 1'b0, 6, 0); gap();     // R5 exactly six
    run_cyc(20'h0F0F0, 8'h00, 1'b0, 1'b0, 11, 0); gap();    // R5 capped
    run_cyc(20'h33333, 8'h77, 1'b1, 1'b0, 2, 1); gap();     // R9 held request
    // R11 back to back: next request raised in the done clock
    run_cyc(20'h11111, 8'h00, 1'b0, 1'b0, 0, 0);
    run_cyc(20'h22222, 8'h99, 1'b1, 1'b1, 3, 0);
    run_cyc(20'h44444, 8'h00, 1'b0, 1'b1, 0, 0); gap();
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_cyc(20'($urandom), 8'($urandom), r[0], r[1], int'(r[7:4] % 9), r[8]);
      if (r[9]) gap();
    end
    gap();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!ended) begin
      ended = 1;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule